// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block decides which interrupt source a processor should service next and whether that source may cut into the handler already running. Each source has a pending bit, an enable bit and a 4-bit priority. A global group setting divides the priority into two parts. The upper part is a preemption level and the lower part is a sub-priority. Among eligible requests the smallest priority wins. Only the preemption level decides whether the winner may interrupt the current handler.

Software sets enable bits through a set-strobe vector and clears them through a clear-strobe vector. A priority is written into an 8-bit register view, and only its upper nibble is kept. When the processor takes the offered request it pulses an acknowledge strobe. The block then records that source as active and pushes its preemption level onto a nesting stack. A completion strobe retires the innermost handler.

Top module: `irq_prio_arbiter`

## Requirements
- R1: A priority write stores only bits [7:4] of the 8-bit write data. Bits [3:0] have no effect on arbitration.
- R2: Each bit at 1 in `en_set` sets that source's enable bit, and each bit at 1 in `en_clr` clears it. A 0 bit leaves the enable unchanged. If both views hit the same bit in one cycle, the clear wins. `en_q` shows the enables one cycle after the write.
- R3: A source is eligible when it is pending, enabled and not active. `win_valid` is 1 exactly when at least one source is eligible. `win_idx` names the eligible source with the numerically smallest 4-bit priority, and the lowest index wins a tie.
- R4: For a group value g from 0 to 4, the preemption level is the top g bits of the priority. Any group value above 4 acts as 4. With g = 0 every source has level 0.
- R5: `preempt_ok` is 1 when all of the following hold: `win_valid` is 1, the nesting stack is not full, and either no handler is active or the winner's level under the current group is strictly smaller than the level stored for the innermost active handler. An equal level never preempts, whatever the sub-priorities are.
- R6: An `ack` in a cycle where `preempt_ok` is 1 clears the winner's pending bit, sets its active flag and pushes its level. An `ack` in any other cycle has no effect.
- R7: A `done` strobe clears the active flag of the innermost handler and pops its level. A `done` with nothing active is ignored.
- R8: When `done` and an effective `ack` fall in the same cycle, the innermost handler is retired and the winner takes its stack slot. `preempt_ok` for that cycle is judged against the handler being retired.
- R9: After reset all pending, enable and active bits are 0, every priority is 0 and the stack is empty.
- R10: A request arriving on `irq_req` in the same cycle that the same source is acknowledged leaves the source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | N_SRC | Per-source request pulses; each 1 sets the pending bit |
| en_set | input | N_SRC | Enable set view; a 1 enables the source |
| en_clr | input | N_SRC | Enable clear view; a 1 disables the source |
| prio_we | input | 1 | Priority register write strobe |
| prio_sel | input | IDX_W | Source whose priority is written |
| prio_wdata | input | PRIO_REG_W | Priority write data; only the upper nibble is kept |
| group | input | 3 | Preemption/sub-priority split setting |
| ack | input | 1 | Processor takes the offered request |
| done | input | 1 | Innermost handler has completed |
| en_q | output | N_SRC | Current enable bits |
| active_q | output | N_SRC | Per-source active (in service) flags |
| win_idx | output | IDX_W | Index of the winning eligible source |
| win_valid | output | 1 | At least one source is eligible |
| preempt_ok | output | 1 | The winner may be taken now |

## Verification
Two pairs of events can fall in the same cycle. The first pair is completion and acknowledge. The bench raises `done` and `ack` together while a handler is active and a lower-level request is waiting. It then checks three things: the old handler's flag is gone, the new handler is active, and the active count is unchanged. The second pair is a fresh request and the acknowledge of that same source. This is provoked on purpose, and the source must still be pending after it leaves service. A behavioural model also drives random overlaps of all strobes and compares the outputs on every clock.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int PRIO_BITS  = 4;
    localparam int GROUP_BITS = 3;

    typedef logic [PRIO_BITS-1:0]  prio_t;
    typedef logic [GROUP_BITS-1:0] group_t;

    // Candidate carried through the selection chain
    typedef struct packed {
        logic  hit;
        prio_t prio;
    } cand_t;

    // Preemption level: the top n bits of the priority, n = min(group, PRIO_BITS)
    function automatic prio_t preempt_level(prio_t p, group_t g);
        int n;
        n = (int'(g) > PRIO_BITS) ? PRIO_BITS : int'(g);
        return prio_t'(p >> (PRIO_BITS - n));
    endfunction
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
    import irq_prio_pkg::*;
#(
    parameter int N_SRC      = 8,
    parameter int PRIO_REG_W = 8,
    localparam int IDX_W     = $clog2(N_SRC)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_SRC-1:0]      irq_req,
    input  logic [N_SRC-1:0]      en_set,
    input  logic [N_SRC-1:0]      en_clr,
    input  logic                  prio_we,
    input  logic [IDX_W-1:0]      prio_sel,
    input  logic [PRIO_REG_W-1:0] prio_wdata,
    input  logic                  take,
    input  logic [IDX_W-1:0]      take_idx,
    output logic [N_SRC-1:0]      pend_q,
    output logic [N_SRC-1:0]      en_q,
    output prio_t                 prio_q [N_SRC]
);
    logic [N_SRC-1:0] take_vec;

    always_comb begin
        take_vec = '0;
        if (take) take_vec[take_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            pend_q <= (pend_q & ~take_vec) | irq_req;
            en_q   <= (en_q | en_set) & ~en_clr;
        end
    end

    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_prio
            always_ff @(posedge clk) begin
                if (rst)
                    prio_q[i] <= '0;
                else if (prio_we && prio_sel == IDX_W'(i))
                    prio_q[i] <= prio_wdata[PRIO_REG_W-1 -: PRIO_BITS];
            end
        end
    endgenerate
endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_prio_pkg::*;
#(
    parameter int N_SRC  = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] en,
    input  logic [N_SRC-1:0] act,
    input  prio_t            prio [N_SRC],
    output logic             valid,
    output logic [IDX_W-1:0] idx,
    output prio_t            best_prio
);
    cand_t best;

    // Linear scan; strict compare keeps the lowest index on ties
    always_comb begin
        best = '0;
        idx  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend[i] && en[i] && !act[i]) begin
                if (!best.hit || prio[i] < best.prio) begin
                    best.hit  = 1'b1;
                    best.prio = prio[i];
                    idx       = IDX_W'(i);
                end
            end
        end
        valid     = best.hit;
        best_prio = best.prio;
    end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
    import irq_prio_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(N_SRC),
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [IDX_W-1:0] push_idx,
    input  prio_t            push_lvl,
    output logic             empty,
    output logic             full,
    output logic [IDX_W-1:0] top_idx,
    output prio_t            top_lvl
);
    logic [IDX_W-1:0] idx_mem [DEPTH];
    prio_t            lvl_mem [DEPTH];
    logic [CW-1:0]    cnt;
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    top_ptr;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign top_ptr = AW'(cnt - CW'(1));
    assign wr_ptr  = pop ? top_ptr : AW'(cnt);
    assign top_idx = idx_mem[top_ptr];
    assign top_lvl = lvl_mem[top_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                idx_mem[i] <= '0;
                lvl_mem[i] <= '0;
            end
        end else begin
            if (push) begin
                idx_mem[wr_ptr] <= push_idx;
                lvl_mem[wr_ptr] <= push_lvl;
            end
            case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_prio_pkg::*;
#(
    parameter int N_SRC       = 8,
    parameter int PRIO_REG_W  = 8,
    parameter int STACK_DEPTH = 1 << PRIO_BITS,
    localparam int IDX_W      = $clog2(N_SRC)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_SRC-1:0]      irq_req,
    input  logic [N_SRC-1:0]      en_set,
    input  logic [N_SRC-1:0]      en_clr,
    input  logic                  prio_we,
    input  logic [IDX_W-1:0]      prio_sel,
    input  logic [PRIO_REG_W-1:0] prio_wdata,
    input  logic [2:0]            group,
    input  logic                  ack,
    input  logic                  done,
    output logic [N_SRC-1:0]      en_q,
    output logic [N_SRC-1:0]      active_q,
    output logic [IDX_W-1:0]      win_idx,
    output logic                  win_valid,
    output logic                  preempt_ok
);
    logic [N_SRC-1:0] pend_q;
    prio_t            prio_q [N_SRC];
    prio_t            win_prio;
    prio_t            win_lvl;
    logic             stk_empty;
    logic             stk_full;
    logic [IDX_W-1:0] top_idx;
    prio_t            top_lvl;
    logic             take;
    logic             retire;
    logic [N_SRC-1:0] set_vec;
    logic [N_SRC-1:0] clr_vec;

    irq_src_regs #(.N_SRC(N_SRC), .PRIO_REG_W(PRIO_REG_W)) u_regs (
        .clk(clk), .rst(rst), .irq_req(irq_req), .en_set(en_set), .en_clr(en_clr),
        .prio_we(prio_we), .prio_sel(prio_sel), .prio_wdata(prio_wdata),
        .take(take), .take_idx(win_idx),
        .pend_q(pend_q), .en_q(en_q), .prio_q(prio_q)
    );

    irq_select #(.N_SRC(N_SRC)) u_sel (
        .pend(pend_q), .en(en_q), .act(active_q), .prio(prio_q),
        .valid(win_valid), .idx(win_idx), .best_prio(win_prio)
    );

    irq_level_stack #(.N_SRC(N_SRC), .DEPTH(STACK_DEPTH)) u_stk (
        .clk(clk), .rst(rst), .push(take), .pop(retire),
        .push_idx(win_idx), .push_lvl(win_lvl),
        .empty(stk_empty), .full(stk_full), .top_idx(top_idx), .top_lvl(top_lvl)
    );

    assign win_lvl    = preempt_level(win_prio, group_t'(group));
    assign preempt_ok = win_valid && !stk_full && (stk_empty || win_lvl < top_lvl);
    assign take       = ack && preempt_ok;
    assign retire     = done && !stk_empty;

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        if (take)   set_vec[win_idx] = 1'b1;
        if (retire) clr_vec[top_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) active_q <= '0;
        else     active_q <= (active_q & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
    parameter int N_SRC  = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input logic             clk,
    input logic             rst,
    input logic [N_SRC-1:0] en_set,
    input logic [N_SRC-1:0] en_clr,
    input logic             ack,
    input logic             done,
    input logic [N_SRC-1:0] en_q,
    input logic [N_SRC-1:0] active_q,
    input logic [IDX_W-1:0] win_idx,
    input logic             win_valid,
    input logic             preempt_ok
);
    // R5
    pok_needs_winner_chk: assert property (@(posedge clk) disable iff (rst)
        preempt_ok |-> win_valid);

    // R3
    winner_eligible_chk: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (en_q[win_idx] && !active_q[win_idx]));

    // R2
    enable_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (en_clr != '0) |=> ((en_q & $past(en_clr)) == '0));

    // R2
    enable_set_chk: assert property (@(posedge clk) disable iff (rst)
        ((en_set & ~en_clr) != '0) |=>
            ((en_q & $past(en_set & ~en_clr)) == $past(en_set & ~en_clr)));

    // R6
    take_marks_active_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && preempt_ok) |=> active_q[$past(win_idx)]);

    // R6
    refused_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !preempt_ok && !done) |=> (active_q == $past(active_q)));

    // R7
    retire_one_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !ack && active_q != '0) |=>
            ($countones(active_q) + 1 == $countones($past(active_q))));

    // R8
    swap_keeps_count_chk: assert property (@(posedge clk) disable iff (rst)
        (done && ack && preempt_ok && active_q != '0) |=>
            ($countones(active_q) == $countones($past(active_q))));

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (en_q == '0 && active_q == '0));
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(.N_SRC(N_SRC)) u_chk (.*);

// File: tb/tb_irq_prio_arbiter.sv
`timescale 1ns/1ps
module tb_irq_prio_arbiter;
    localparam int N     = 8;
    localparam int IW    = 3;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_req = '0, en_set = '0, en_clr = '0;
    logic          prio_we = 1'b0;
    logic [IW-1:0] prio_sel = '0;
    logic [7:0]    prio_wdata = '0;
    logic [2:0]    group = 3'd2;
    logic          ack = 1'b0, done = 1'b0;
    logic [N-1:0]  en_q, active_q;
    logic [IW-1:0] win_idx;
    logic          win_valid, preempt_ok;

    int checks = 0;
    int errors = 0;

    irq_prio_arbiter dut (.*);

    always #10 clk = ~clk;

    // Behavioural reference state
    bit m_pend [N];
    bit m_en   [N];
    bit m_act  [N];
    int m_pr   [N];
    int s_idx [$];
    int s_lvl [$];

    function automatic int lvl_of(int p, int g);
        int n = (g > 4) ? 4 : g;
        return p >> (4 - n);
    endfunction

    function automatic void m_eval(output bit v, output int w, output bit pok);
        v = 0; w = 0;
        for (int i = 0; i < N; i++)
            if (m_pend[i] && m_en[i] && !m_act[i] && (!v || m_pr[i] < m_pr[w])) begin
                v = 1; w = i;
            end
        pok = v && (s_lvl.size() < DEPTH) &&
              (s_lvl.size() == 0 || lvl_of(m_pr[w], int'(group)) < s_lvl[$]);
    endfunction

    task automatic chk(string req, int act_v, int exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act_v, exp_v, $time);
        end
    endtask

    always @(posedge clk) begin
        bit v, pok;
        int w;
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_pend[i] = 0; m_en[i] = 0; m_act[i] = 0; m_pr[i] = 0;
            end
            s_idx.delete(); s_lvl.delete();
        end else begin
            m_eval(v, w, pok);
            if (done && s_idx.size() > 0) begin
                m_act[s_idx[$]] = 0;
                void'(s_idx.pop_back()); void'(s_lvl.pop_back());
            end
            if (ack && pok) begin
                m_pend[w] = 0; m_act[w] = 1;
                s_idx.push_back(w); s_lvl.push_back(lvl_of(m_pr[w], int'(group)));
            end
            for (int i = 0; i < N; i++) begin
                if (irq_req[i]) m_pend[i] = 1;
                if (en_set[i])  m_en[i] = 1;
                if (en_clr[i])  m_en[i] = 0;
            end
            if (prio_we) m_pr[prio_sel] = int'(prio_wdata[7:4]);
        end
    end

    // Compare with the model every cycle, away from the active edge
    always @(negedge clk) begin
        bit v, pok;
        int w;
        if (!rst) begin
            m_eval(v, w, pok);
            for (int i = 0; i < N; i++) begin
                chk("R2 en_q bit", int'(en_q[i]), int'(m_en[i]));
                chk("R6 active_q bit", int'(active_q[i]), int'(m_act[i]));
            end
            chk("R3 win_valid", int'(win_valid), int'(v));
            if (v) chk("R3 win_idx", int'(win_idx), w);
            chk("R5 preempt_ok", int'(preempt_ok), int'(pok));
        end
    end

    task automatic cyc();
        @(posedge clk); #2;
        irq_req = '0; en_set = '0; en_clr = '0; prio_we = 1'b0; ack = 1'b0; done = 1'b0;
    endtask

    task automatic wprio(int idx, int val);
        prio_we = 1'b1; prio_sel = IW'(idx); prio_wdata = 8'(val);
        cyc();
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R9 reset state
        chk("R9 en_q", int'(en_q), 0);
        chk("R9 active_q", int'(active_q), 0);
        chk("R9 win_valid", int'(win_valid), 0);

        // R1: upper nibble only; 0x5F on src3 ties with 0x50 on src5
        wprio(3, 'h5F);
        wprio(5, 'h50);
        en_set = 8'h28; cyc();
        irq_req = 8'h28; cyc();
        chk("R1 tie on upper nibble", int'(win_idx), 3);

        // R2: set and clear same bit, clear wins
        en_set = 8'h08; en_clr = 8'h08; cyc();
        chk("R2 clear beats set", int'(en_q[3]), 0);
        chk("R3 next winner", int'(win_idx), 5);
        en_clr = 8'h20; cyc();
        chk("R3 nothing eligible", int'(win_valid), 0);

        // Group 2 example: src0 (2,1)=9, src1 (3,0)=12, src2 (2,0)=8
        wprio(0, 'h90); wprio(1, 'hC0); wprio(2, 'h80);
        group = 3'd2;
        en_set = 8'h07; cyc();
        irq_req = 8'h07; cyc();
        chk("R3 lowest sub-priority wins", int'(win_idx), 2);
        chk("R5 idle preempt", int'(preempt_ok), 1);
        ack = 1'b1; cyc();
        chk("R6 ack sets active", int'(active_q), 'h04);
        chk("R5 equal level blocked", int'(preempt_ok), 0);
        chk("R3 winner after ack", int'(win_idx), 0);
        ack = 1'b1; cyc();
        chk("R6 refused ack ignored", int'(active_q), 'h04);

        // R4: group 7 acts as 4 -> level 9 vs stored 2: still blocked
        group = 3'd7; cyc();
        chk("R4 group above 4", int'(preempt_ok), 0);

        // Nest: src4 prio 0x10 level 0 under group 2 preempts level 2
        group = 3'd2;
        wprio(4, 'h10);
        en_set = 8'h10; cyc();
        irq_req = 8'h10; cyc();
        chk("R5 lower level preempts", int'(preempt_ok), 1);
        // R10: re-request of src4 in same cycle as its ack
        ack = 1'b1; irq_req = 8'h10; cyc();
        chk("R6 nested active", int'(active_q), 'h14);
        // R4: group 0 puts src0 at level 0 vs stored 0: blocked
        group = 3'd0; cyc();
        chk("R4 group zero no preempt", int'(preempt_ok), 0);
        group = 3'd2;
        // R7 retire src4, then src4 pending again (R10) wins
        done = 1'b1; cyc();
        chk("R7 done pops innermost", int'(active_q), 'h04);
        chk("R10 request kept pending", int'(win_idx), 4);
        chk("R10 pending preempts", int'(preempt_ok), 1);

        // R8: done plus ack together: src2 retired, src4 takes its slot
        done = 1'b1; ack = 1'b1; cyc();
        chk("R8 swap active", int'(active_q), 'h10);
        done = 1'b1; cyc();
        chk("R7 back to idle", int'(active_q), 0);
        done = 1'b1; cyc();
        chk("R7 done on empty ignored", int'(active_q), 0);

        // Random overlap of all strobes, checked by the model every clock
        for (int k = 0; k < 600; k++) begin
            irq_req = N'($urandom) & N'($urandom);
            en_set  = N'($urandom) & N'($urandom) & N'($urandom);
            en_clr  = N'($urandom) & N'($urandom) & N'($urandom) & N'($urandom);
            if ($urandom_range(0, 7) == 0) begin
                prio_we = 1'b1; prio_sel = IW'($urandom); prio_wdata = 8'($urandom);
            end
            if ($urandom_range(0, 15) == 0) group = 3'($urandom);
            ack  = ($urandom_range(0, 1) == 1);
            done = ($urandom_range(0, 3) == 0);
            cyc();
        end

        repeat (2) cyc();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule